// File: doc/BRIEF.md
# CPU Clock Rate-Change Sequencer

This controller retunes the PLL that clocks a CPU core so that the core never sees a glitch or an out-of-range clock. A request carries an index into a fixed set of eleven target rates. For the chosen target, the block derives the feedback multiplier and the output-divider code. It moves the CPU clock mux onto the crystal reference and waits for a settling interval that grows with the rate being left. It then writes the new PLL control word and moves the mux back to the PLL. After a lock interval that depends on both the old and the new rate, it samples the PLL lock flag.

If the PLL has not locked, the write, reselect and wait steps are repeated. Once lock is seen, a one-cycle completion pulse tells software that rate-dependent timers can be refreshed. If lock never arrives within a set number of attempts, the sequence gives up and leaves the core on the crystal. All wait lengths come from tables that are worked out once at elaboration, so the block needs no divider at run time.

Top module: `pll_freq_seq`

## Requirements
- R1: Index k in 0..10 selects, in this order, 1536, 1488, 1320, 1200, 1008, 816, 720, 600, 504, 408 and 312 MHz. The control word for a target places the multiplier in bits 8:0, a pre-divider of 1 in bits 14:9 and the output-divider code in bits 17:16. All other bits are zero, bit 31 included.
- R2: The multiplier is (rate / XTAL_MHZ) scaled by 4 with divider code 2 below 600 MHz, scaled by 2 with code 1 from 600 MHz up to 1199 MHz, and left unscaled with code 0 at 1200 MHz and above.
- R3: The request is sampled while idle. On the edge that accepts a valid request, `busy` rises and `clkSel` falls to 0 (crystal), before any control word is written.
- R4: The first control-word write comes exactly S = max(1, SETTLE_MUL × old rate / XTAL_MHZ) cycles after acceptance, using integer division. `clkSel` stays 0 for all of those cycles.
- R5: Every write pulses `pllWrite` for one cycle. `clkSel` returns to 1 on the same edge as the first write.
- R6: The lock input is sampled L = max(2, LOCK_MUL × old rate / new rate) cycles after each write. If it is low and fewer than MAX_TRIES writes have been made, the same word is written again.
- R7: When lock is sampled high, `done` pulses for one cycle and `busy` falls on the same edge. The target then becomes the old rate for the next request.
- R8: A request made while `busy` is high has no effect. The written word and the timing are those of the request already in progress.
- R9: An index of 11 or more, requested while idle, gives a one-cycle `reqErr` pulse. `busy` stays low and the control word does not change.
- R10: After MAX_TRIES writes without lock, `lockErr` is set, `busy` falls, `clkSel` goes to 0 and there is no `done` pulse. The old rate stays as it was, and `lockErr` clears on the next accepted request.
- R11: After reset, `busy`, `done`, `reqErr`, `lockErr` and `pllWrite` are 0, `clkSel` is 1, and the control word is that of RESET_IDX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-domain clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Rate-change request, sampled while idle |
| reqIdx | input | IDX_W | Target rate index |
| busy | output | 1 | A rate change is in progress |
| done | output | 1 | One-cycle pulse when lock is reached |
| reqErr | output | 1 | One-cycle pulse for an out-of-range index |
| lockErr | output | 1 | The last sequence ran out of lock attempts |
| pllWord | output | 32 | PLL control word |
| pllWrite | output | 1 | One-cycle strobe for each control-word write |
| pllLock | input | 1 | Lock flag from the PLL |
| clkSel | output | 1 | CPU clock mux select: 1 selects the PLL, 0 the crystal |

## Verification
A PLL model in the bench raises lock only after a chosen number of writes. This lets a single transition be run three ways: with immediate lock, with one retry, and with no lock at all, and these three cases separate the retry and give-up paths.

Directed transitions cross the 600 MHz and 1200 MHz band edges and use the lowest target. They show whether the divider code and the multiplier scaling switch at the right rate. Random chains of transitions then vary both the old and the new rate, so that a settling or lock interval taken from the wrong side of the transition shows up as a timing error.

Out-of-range indices and requests made in the middle of a sequence check that stray requests are rejected or ignored. A transition made right after a failed one checks that the old rate was kept.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int NUM_RATES = 11;

  // control -> datapath strobes
  typedef struct packed {
    logic accept;     // latch target, load settling count
    logic writeWord;  // write control word, load lock count
    logic commit;     // target becomes current rate
  } seqStrb_t;

  function automatic int rateMhz(input int idx);
    case (idx)
      0: return 1536;
      1: return 1488;
      2: return 1320;
      3: return 1200;
      4: return 1008;
      5: return 816;
      6: return 720;
      7: return 600;
      8: return 504;
      9: return 408;
      default: return 312;
    endcase
  endfunction

  function automatic int odCode(input int rate);
    if (rate < 600) return 2;
    else if (rate < 1200) return 1;
    else return 0;
  endfunction

  function automatic logic [31:0] makeWord(input int idx, input int xtal);
    logic [31:0] w;
    int od;
    int mul;
    od  = odCode(rateMhz(idx));
    mul = (rateMhz(idx) / xtal) << od;
    w = '0;
    w[8:0]   = 9'(mul);
    w[14:9]  = 6'd1;
    w[17:16] = 2'(od);
    return w;
  endfunction

endpackage

// File: rtl/pll_seq_dp.sv
module pll_seq_dp
  import pll_seq_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int CNT_W      = 14,
  parameter int TRY_W      = 3,
  parameter int XTAL_MHZ   = 24,
  parameter int SETTLE_MUL = 100,
  parameter int LOCK_MUL   = 500,
  parameter int MAX_TRIES  = 4,
  parameter int RESET_IDX  = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrb_t         strb,
  input  logic [IDX_W-1:0] reqIdx,
  output logic             idxValid,
  output logic             cntZero,
  output logic             lastTry,
  output logic [31:0]      pllWord,
  output logic             pllWrite
);

  localparam int SEL_W  = $clog2(NUM_RATES);
  localparam int LSEL_W = $clog2(NUM_RATES * NUM_RATES);

  function automatic int settleCycles(input int oldI);
    int v;
    v = SETTLE_MUL * rateMhz(oldI) / XTAL_MHZ;
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int lockCycles(input int oldI, input int newI);
    int v;
    v = LOCK_MUL * rateMhz(oldI) / rateMhz(newI);
    return (v < 2) ? 2 : v;
  endfunction

  logic [31:0]      wordTab   [NUM_RATES];
  logic [CNT_W-1:0] settleTab [NUM_RATES];
  logic [CNT_W-1:0] lockTab   [NUM_RATES*NUM_RATES];

  for (genvar i = 0; i < NUM_RATES; i++) begin : g_old
    assign wordTab[i]   = makeWord(i, XTAL_MHZ);
    assign settleTab[i] = CNT_W'(settleCycles(i));
    for (genvar j = 0; j < NUM_RATES; j++) begin : g_new
      assign lockTab[i*NUM_RATES+j] = CNT_W'(lockCycles(i, j));
    end
  end

  logic [IDX_W-1:0]  curIdx;
  logic [IDX_W-1:0]  newIdx;
  logic [CNT_W-1:0]  cnt;
  logic [TRY_W-1:0]  tries;
  logic [LSEL_W-1:0] lockSel;

  assign lockSel  = LSEL_W'(curIdx) * LSEL_W'(NUM_RATES) + LSEL_W'(newIdx);
  assign idxValid = (reqIdx < IDX_W'(NUM_RATES));
  assign cntZero  = (cnt == '0);
  assign lastTry  = (tries >= TRY_W'(MAX_TRIES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx   <= IDX_W'(RESET_IDX);
      newIdx   <= IDX_W'(RESET_IDX);
      cnt      <= '0;
      tries    <= '0;
      pllWord  <= makeWord(RESET_IDX, XTAL_MHZ);
      pllWrite <= 1'b0;
    end else begin
      pllWrite <= 1'b0;
      if (strb.accept) begin
        newIdx <= reqIdx;
        cnt    <= settleTab[SEL_W'(curIdx)] - 1'b1;
        tries  <= '0;
      end else if (strb.writeWord) begin
        cnt      <= lockTab[lockSel] - 1'b1;
        pllWord  <= wordTab[SEL_W'(newIdx)];
        pllWrite <= 1'b1;
        tries    <= tries + 1'b1;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
      if (strb.commit) curIdx <= newIdx;
    end
  end

  // R1: word only changes on a write strobe
  p_word_on_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    !pllWrite |-> pllWord == $past(pllWord));
  // R5: write strobe lasts one cycle
  p_write_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    pllWrite |=> !pllWrite);
  // R1: pre-divider field is fixed at one
  always_comb begin
    if (rstN) p_prediv_r1: assert (pllWord[14:9] == 6'd1);
  end

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     req,
  input  logic     idxValid,
  input  logic     cntZero,
  input  logic     lastTry,
  input  logic     pllLock,
  output seqStrb_t strb,
  output logic     busy,
  output logic     done,
  output logic     reqErr,
  output logic     lockErr,
  output logic     clkSel
);

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_LOCKWAIT} seqState_t;
  seqState_t state;

  always_comb begin
    strb.accept    = (state == S_IDLE) && req && idxValid;
    strb.writeWord = ((state == S_SETTLE) && cntZero) ||
                     ((state == S_LOCKWAIT) && cntZero && !pllLock && !lastTry);
    strb.commit    = (state == S_LOCKWAIT) && cntZero && pllLock;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      reqErr  <= 1'b0;
      lockErr <= 1'b0;
      clkSel  <= 1'b1;
    end else begin
      done   <= 1'b0;
      reqErr <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          if (idxValid) begin
            busy    <= 1'b1;
            clkSel  <= 1'b0;
            lockErr <= 1'b0;
            state   <= S_SETTLE;
          end else begin
            reqErr <= 1'b1;
          end
        end
        S_SETTLE: if (cntZero) begin
          clkSel <= 1'b1;
          state  <= S_LOCKWAIT;
        end
        S_LOCKWAIT: if (cntZero) begin
          if (pllLock) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else if (lastTry) begin
            lockErr <= 1'b1;
            clkSel  <= 1'b0;
            busy    <= 1'b0;
            state   <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: entering a sequence parks the clock on the crystal
  p_busy_crystal_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !clkSel);
  // R7: done is a single-cycle pulse outside busy
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R9: request error only while idle, one cycle
  p_reqerr_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> !busy && !done);
  // R10: failed sequence leaves the core on the crystal
  p_fail_crystal_r10: assert property (@(posedge clk) disable iff (!rstN)
    lockErr |-> !clkSel && !busy);

endmodule

// File: rtl/pll_freq_seq.sv
module pll_freq_seq
  import pll_seq_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int CNT_W      = 14,
  parameter int XTAL_MHZ   = 24,
  parameter int SETTLE_MUL = 100,
  parameter int LOCK_MUL   = 500,
  parameter int MAX_TRIES  = 4,
  parameter int RESET_IDX  = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             req,
  input  logic [IDX_W-1:0] reqIdx,
  output logic             busy,
  output logic             done,
  output logic             reqErr,
  output logic             lockErr,
  output logic [31:0]      pllWord,
  output logic             pllWrite,
  input  logic             pllLock,
  output logic             clkSel
);

  localparam int TRY_W = $clog2(MAX_TRIES + 1);

  seqStrb_t strb;
  logic     idxValid;
  logic     cntZero;
  logic     lastTry;

  pll_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .idxValid(idxValid),
    .cntZero(cntZero), .lastTry(lastTry), .pllLock(pllLock),
    .strb(strb), .busy(busy), .done(done), .reqErr(reqErr),
    .lockErr(lockErr), .clkSel(clkSel)
  );

  pll_seq_dp #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .TRY_W(TRY_W), .XTAL_MHZ(XTAL_MHZ),
    .SETTLE_MUL(SETTLE_MUL), .LOCK_MUL(LOCK_MUL),
    .MAX_TRIES(MAX_TRIES), .RESET_IDX(RESET_IDX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqIdx(reqIdx),
    .idxValid(idxValid), .cntZero(cntZero), .lastTry(lastTry),
    .pllWord(pllWord), .pllWrite(pllWrite)
  );

  // R5: mux returns to the PLL only together with a write
  p_sel_with_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkSel) |-> pllWrite);
  p_write_on_pll_r5: assert property (@(posedge clk) disable iff (!rstN)
    pllWrite |-> clkSel && busy);

endmodule

// File: tb/pll_freq_seq_tb.sv
module pll_freq_seq_tb;

  localparam int XTAL   = 24;
  localparam int SMUL   = 10;
  localparam int LMUL   = 50;
  localparam int TRIES  = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic [3:0]  reqIdx = '0;
  logic        busy, done, reqErr, lockErr, pllWrite, clkSel;
  logic [31:0] pllWord;
  logic        pllLock;

  int checks = 0;
  int errors = 0;
  int curModel = 0;
  int needW = 1;
  int wcnt = 0;
  logic xferClr = 1'b0;

  always #5 clk = ~clk;

  pll_freq_seq #(
    .XTAL_MHZ(XTAL), .SETTLE_MUL(SMUL), .LOCK_MUL(LMUL),
    .MAX_TRIES(TRIES), .RESET_IDX(0)
  ) u_dut (
    .clk(clk), .rstN(rstN), .req(req), .reqIdx(reqIdx), .busy(busy),
    .done(done), .reqErr(reqErr), .lockErr(lockErr), .pllWord(pllWord),
    .pllWrite(pllWrite), .pllLock(pllLock), .clkSel(clkSel)
  );

  // PLL model: locks once enough writes have arrived
  always @(posedge clk) begin
    if (!rstN || xferClr) begin
      wcnt    <= 0;
      pllLock <= 1'b0;
    end else if (pllWrite) begin
      wcnt    <= wcnt + 1;
      pllLock <= 1'b0;
    end else begin
      pllLock <= (wcnt >= needW);
    end
  end

  function automatic int expRate(input int k);
    int t[11] = '{1536, 1488, 1320, 1200, 1008, 816, 720, 600, 504, 408, 312};
    return t[k];
  endfunction

  function automatic logic [31:0] expWord(input int k);
    int r, od, m;
    r  = expRate(k);
    od = (r < 600) ? 2 : (r < 1200) ? 1 : 0;
    m  = (r / XTAL) * ((od == 2) ? 4 : (od == 1) ? 2 : 1);
    return (32'(od) << 16) | (32'd1 << 9) | 32'(m);
  endfunction

  function automatic int expSettle(input int o);
    int v = SMUL * expRate(o) / XTAL;
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int expLock(input int o, input int n);
    int v = LMUL * expRate(o) / expRate(n);
    return (v < 2) ? 2 : v;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic doXfer(input int idx, input int need, input bit poke);
    int s, l, wr, zeroCnt, firstW, lastW, doneT, gapBad;
    bit sawErr;
    bit ok;
    s = expSettle(curModel);
    l = expLock(curModel, idx);
    ok = (need <= TRIES);
    needW = need;
    wr = 0; zeroCnt = 0; firstW = -1; lastW = -1; doneT = -1; gapBad = 0; sawErr = 0;
    @(negedge clk); xferClr = 1'b1;
    @(negedge clk); xferClr = 1'b0; req = 1'b1; reqIdx = 4'(idx);
    @(negedge clk); req = 1'b0;
    chk(busy == 1'b1 && clkSel == 1'b0, "R3", {busy, clkSel}, 2);
    for (int t = 0; t < 20000; t++) begin
      if (poke && t == 2) begin req = 1'b1; reqIdx = 4'((idx + 5) % 16); end
      if (poke && t == 3) req = 1'b0;
      if (reqErr) sawErr = 1;
      if (pllWrite) begin
        if (wr == 0) begin
          firstW = t;
          chk(clkSel == 1'b1, "R5", clkSel, 1);
        end else if (t - lastW != l) gapBad++;
        wr++;
        lastW = t;
      end
      if (wr == 0 && !clkSel) zeroCnt++;
      if (done) doneT = t;
      if (!busy) break;
      @(negedge clk);
    end
    chk(firstW == s, "R4", firstW, s);
    chk(zeroCnt == s, "R4", zeroCnt, s);
    chk(gapBad == 0, "R6", gapBad, 0);
    if (poke) chk(!sawErr, "R8", sawErr, 0);
    if (ok) begin
      chk(wr == need, "R6", wr, need);
      chk(doneT == lastW + l, "R7", doneT, lastW + l);
      chk(pllWord == expWord(idx), "R1 R2", pllWord, expWord(idx));
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R7", {done, busy}, 0);
      curModel = idx;
    end else begin
      chk(wr == TRIES, "R10", wr, TRIES);
      chk(doneT == -1, "R10", doneT, -1);
      @(negedge clk);
      chk(lockErr && !clkSel && !busy, "R10", {lockErr, clkSel, busy}, 4);
    end
  endtask

  task automatic badReq(input int idx);
    logic [31:0] w;
    w = pllWord;
    @(negedge clk); req = 1'b1; reqIdx = 4'(idx);
    @(negedge clk); req = 1'b0;
    chk(reqErr == 1'b1 && busy == 1'b0, "R9", {reqErr, busy}, 2);
    @(negedge clk);
    chk(reqErr == 1'b0 && busy == 1'b0 && pllWord == w, "R9", pllWord, w);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20151129);
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && reqErr == 0 && lockErr == 0 && pllWrite == 0 && clkSel == 1,
        "R11", {busy, done, reqErr, lockErr, pllWrite, clkSel}, 1);
    chk(pllWord == expWord(0), "R11", pllWord, expWord(0));
    rstN = 1'b1;
    @(negedge clk);
    doXfer(10, 1, 0);   // lowest target, divider code 2
    doXfer(3, 1, 0);    // 1200 edge, code 0
    doXfer(7, 1, 0);    // 600 edge, code 1
    doXfer(8, 1, 0);    // just below 600
    doXfer(4, 2, 0);    // one retry
    doXfer(1, 9, 0);    // never locks
    doXfer(9, 1, 0);    // old rate kept after failure
    chk(lockErr == 1'b0, "R10", lockErr, 0);
    doXfer(2, 1, 1);    // request while busy
    badReq(11);
    badReq(15);
    for (int n = 0; n < 20; n++) begin
      doXfer(int'($urandom % 11), int'($urandom % 2) + 1, n % 4 == 0);
    end
    badReq(12);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule